// File: doc/BRIEF.md
# Ready-Gated Slow SPI Host

This block is the host side of a byte-wide SPI link to a single slow slave that has a data-ready line. A request brings in a command byte. The host then waits until the slave reports ready and drops the active-low select. It waits a setup interval, then runs eight clock cycles. The clock idles high. MOSI changes on each falling edge and MISO is captured on each rising edge, most significant bit first. After the last rising edge the host keeps select low for a hold interval. It then releases select and, on the same edge, pulses done with the byte it received.

Every timing interval is counted in system clocks: the clock half-period, the setup gap and the hold gap. Each one is a parameter, and at elaboration it is clamped into a minimum and maximum window. The slave's limits, for example a 5 to 40 kHz serial clock, phases over about 12 us, a setup gap over about 35 us and a hold over about 12 us, then follow from the parameters. The ready line is synchronised into the system clock. If ready stays low for too long while a request waits, the host gives up, pulses an error flag and returns to idle without selecting the slave.

Top module: `rdy_spi_host`

## Requirements
- R1: While reset is held and right after it, select and the serial clock are high, and busy, done and the error flag are low.
- R2: A start in idle captures the command byte and raises busy on the next cycle. Busy stays high until the cycle after done. A start while busy is ignored and begins no second transfer.
- R3: Select never falls while the synchronised ready is low. When ready rises during a wait, select falls on the third clock edge after it, because of the two-stage synchroniser.
- R4: If synchronised ready stays low for RDY_TIMEOUT cycles in the wait state, the error flag pulses for one cycle and the block returns to idle. Select does not fall and done does not pulse.
- R5: The first falling serial clock edge comes exactly SETUP_EFF cycles after select falls.
- R6: The serial clock idles high whenever select is high. Each transfer has exactly 8 falling and 8 rising edges. Every low phase and every high phase between edges lasts HALF_EFF cycles.
- R7: MOSI carries the command byte most significant bit first, and it changes only together with a falling serial clock edge.
- R8: The response byte holds the MISO values captured at the 8 rising edges, with the first capture in bit 7.
- R9: Select rises exactly HOLD_EFF cycles after the last rising edge. Done is high for exactly that one cycle. The response is valid then and stays unchanged until the next done.
- R10: Each effective interval X_EFF equals its parameter clamped into [X_LO, X_HI], and is never less than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle transfer request, taken only in idle |
| cmd_i | input | FRAME_BITS | Command byte captured with start_i |
| busy_o | output | 1 | High from the cycle after an accepted start until idle again |
| done_o | output | 1 | One-cycle pulse when select is released |
| resp_o | output | FRAME_BITS | Byte received from the slave, held until the next done |
| rdy_err_o | output | 1 | One-cycle pulse when the wait for ready times out |
| sclk_o | output | 1 | Serial clock, idles high |
| ss_n_o | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Host data to the slave |
| miso_i | input | 1 | Slave data to the host |
| rdy_i | input | 1 | Slave ready line, asynchronous |

## Verification
The assertions assume that start_i is a clean single-cycle pulse and that MISO is already settled when the host's rising edge comes. That second assumption is what makes the phase-length and sampling checks meaningful. The ready check uses the synchronised ready, not the raw pin, so it assumes ready is held for at least the two synchroniser cycles. The bench's slave model changes MISO only at the clock sample that follows a falling serial edge. It moves ready only at falling system-clock edges, and it lowers ready three cycles before a request so that the synchroniser has settled low before the wait starts.

// File: rtl/rsh_pkg.sv
`timescale 1ns/1ps
package rsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_LO,
    ST_HI,
    ST_HOLD,
    ST_DONE
  } rsh_state_e;

  // Clamp an interval into its window; zero is never a legal length.
  function automatic int unsigned rsh_fit(input int unsigned v,
                                          input int unsigned lo,
                                          input int unsigned hi);
    int unsigned r;
    r = v;
    if (r < lo) r = lo;
    if (r > hi) r = hi;
    if (r == 0) r = 1;
    return r;
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int unsigned rsh_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned rsh_max3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rsh_ready_watch.sv
`timescale 1ns/1ps
module rsh_ready_watch #(
  parameter int unsigned TMO_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_i,
  input  logic arm_i,
  output logic rdy_ok_o,
  output logic tmo_o
);
  import rsh_pkg::*;

  localparam int unsigned WW = rsh_bits(TMO_CYC);
  localparam logic [WW-1:0] WT_LAST = WW'(TMO_CYC - 1);

  logic          sync1_q, sync2_q;
  logic [WW-1:0] wt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= rdy_i;
      sync2_q <= sync1_q;
    end
  end

  assign rdy_ok_o = sync2_q;
  assign tmo_o    = arm_i && !sync2_q && (wt_q == WT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wt_q <= '0;
    else if (!arm_i)            wt_q <= '0;
    else if (!sync2_q && !tmo_o) wt_q <= wt_q + 1'b1;
  end
endmodule

// File: rtl/rsh_interval.sv
`timescale 1ns/1ps
module rsh_interval #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rsh_shifter.sv
`timescale 1ns/1ps
module rsh_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] cmd_i,
  input  logic          drive_i,
  input  logic          sample_i,
  input  logic          miso_i,
  output logic          mosi_o,
  output logic          last_o,
  output logic [DW-1:0] rx_o
);
  localparam int unsigned BW = (DW < 2) ? 1 : $clog2(DW);
  localparam logic [BW-1:0] LAST_IDX = BW'(DW - 1);

  logic [DW-1:0] tx_q, rx_q;
  logic [BW-1:0] nbit_q;
  logic          mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      nbit_q <= '0;
      mosi_q <= 1'b0;
    end else begin
      if (load_i) begin
        tx_q   <= cmd_i;
        nbit_q <= '0;
      end else if (drive_i) begin
        mosi_q <= tx_q[DW-1];
        tx_q   <= {tx_q[DW-2:0], 1'b0};
      end
      if (sample_i) begin
        rx_q   <= {rx_q[DW-2:0], miso_i};
        nbit_q <= nbit_q + 1'b1;
      end
    end
  end

  assign mosi_o = mosi_q;
  assign last_o = (nbit_q == LAST_IDX);
  assign rx_o   = rx_q;
endmodule

// File: rtl/rdy_spi_host.sv
`timescale 1ns/1ps
module rdy_spi_host #(
  parameter int unsigned FRAME_BITS  = 8,
  parameter int unsigned HALF_CYC    = 1600,
  parameter int unsigned HALF_LO     = 1563,
  parameter int unsigned HALF_HI     = 12500,
  parameter int unsigned SETUP_CYC   = 4500,
  parameter int unsigned SETUP_LO    = 4375,
  parameter int unsigned SETUP_HI    = 12500,
  parameter int unsigned HOLD_CYC    = 1600,
  parameter int unsigned HOLD_LO     = 1500,
  parameter int unsigned HOLD_HI     = 12500,
  parameter int unsigned RDY_TIMEOUT = 125000000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] cmd_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] resp_o,
  output logic                  rdy_err_o,
  output logic                  sclk_o,
  output logic                  ss_n_o,
  output logic                  mosi_o,
  input  logic                  miso_i,
  input  logic                  rdy_i
);
  import rsh_pkg::*;

  localparam int unsigned HALF_EFF  = rsh_fit(HALF_CYC, HALF_LO, HALF_HI);
  localparam int unsigned SETUP_EFF = rsh_fit(SETUP_CYC, SETUP_LO, SETUP_HI);
  localparam int unsigned HOLD_EFF  = rsh_fit(HOLD_CYC, HOLD_LO, HOLD_HI);
  localparam int unsigned TW = rsh_bits(rsh_max3(HALF_EFF, SETUP_EFF, HOLD_EFF));

  rsh_state_e state_q, state_d;

  // Named internal events, also seen by the bound checker.
  logic rdy_ok, ev_tmo, ev_start, t_zero, last_bit;
  logic tmr_load, bit_drive, bit_sample;
  logic [TW-1:0] tmr_len;
  logic [FRAME_BITS-1:0] rx_bits;

  logic ss_q, sclk_q, done_q, err_q;
  logic [FRAME_BITS-1:0] resp_q;

  assign ev_start = start_i && (state_q == ST_IDLE);

  rsh_ready_watch #(.TMO_CYC(RDY_TIMEOUT)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_i    (rdy_i),
    .arm_i    (state_q == ST_WAIT),
    .rdy_ok_o (rdy_ok),
    .tmo_o    (ev_tmo)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (ev_tmo)      state_d = ST_IDLE;
        else if (rdy_ok) state_d = ST_SETUP;
      end
      ST_SETUP: if (t_zero) state_d = ST_LO;
      ST_LO:    if (t_zero) state_d = last_bit ? ST_HOLD : ST_HI;
      ST_HI:    if (t_zero) state_d = ST_LO;
      ST_HOLD:  if (t_zero) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state_q) &&
                    (state_d inside {ST_SETUP, ST_LO, ST_HI, ST_HOLD});

  always_comb begin
    unique case (state_d)
      ST_SETUP: tmr_len = TW'(SETUP_EFF);
      ST_HOLD:  tmr_len = TW'(HOLD_EFF);
      default:  tmr_len = TW'(HALF_EFF);
    endcase
  end

  rsh_interval #(.TW(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .zero_o (t_zero)
  );

  assign bit_drive  = (state_q != ST_LO) && (state_d == ST_LO);
  assign bit_sample = (state_q == ST_LO) && t_zero;

  rsh_shifter #(.DW(FRAME_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (ev_start),
    .cmd_i    (cmd_i),
    .drive_i  (bit_drive),
    .sample_i (bit_sample),
    .miso_i   (miso_i),
    .mosi_o   (mosi_o),
    .last_o   (last_bit),
    .rx_o     (rx_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ss_q    <= 1'b1;
      sclk_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      resp_q  <= '0;
    end else begin
      state_q <= state_d;
      ss_q    <= !(state_d inside {ST_SETUP, ST_LO, ST_HI, ST_HOLD});
      sclk_q  <= (state_d != ST_LO);
      done_q  <= (state_d == ST_DONE);
      err_q   <= ev_tmo;
      if (state_d == ST_DONE) resp_q <= rx_bits;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign resp_o    = resp_q;
  assign rdy_err_o = err_q;
  assign ss_n_o    = ss_q;
  assign sclk_o    = sclk_q;
endmodule

// File: rtl/rsh_checker.sv
`timescale 1ns/1ps
module rsh_checker #(
  parameter int unsigned HALF_EFF = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic rdy_err_o,
  input logic ss_n_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic rdy_ok
);
  int unsigned low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_len <= 0;
    else if (!sclk_o) low_len <= low_len + 1;
    else              low_len <= 0;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_sel_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n_o) |-> $past(rdy_ok));

  p_err_unselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_err_o |-> (ss_n_o && !done_o));

  p_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_err_o |=> !busy_o);

  p_clock_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_o |-> sclk_o);

  p_low_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (low_len == HALF_EFF));

  p_mosi_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> $fell(sclk_o));

  p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n_o) |-> done_o);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind rdy_spi_host rsh_checker #(.HALF_EFF(HALF_EFF)) u_rsh_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rdy_err_o (rdy_err_o),
  .ss_n_o    (ss_n_o),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .rdy_ok    (rdy_ok)
);

// File: tb/rdy_spi_host_test.sv
`timescale 1ns/1ps
module rdy_spi_host_test;
  localparam int unsigned HALF_CYC = 2,  HALF_LO = 4,  HALF_HI = 10;
  localparam int unsigned SETUP_CYC = 20, SETUP_LO = 3, SETUP_HI = 9;
  localparam int unsigned HOLD_CYC = 5,  HOLD_LO = 2,  HOLD_HI = 8;
  localparam int unsigned TMO = 20;

  function automatic int bound(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  localparam int HALF_E = bound(HALF_CYC, HALF_LO, HALF_HI);
  localparam int SET_E  = bound(SETUP_CYC, SETUP_LO, SETUP_HI);
  localparam int HOLD_E = bound(HOLD_CYC, HOLD_LO, HOLD_HI);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic rdy_i = 1'b1;
  logic miso_i;
  logic busy_o, done_o, rdy_err_o, sclk_o, ss_n_o, mosi_o;
  logic [7:0] resp_o;

  rdy_spi_host #(
    .FRAME_BITS(8),
    .HALF_CYC(HALF_CYC), .HALF_LO(HALF_LO), .HALF_HI(HALF_HI),
    .SETUP_CYC(SETUP_CYC), .SETUP_LO(SETUP_LO), .SETUP_HI(SETUP_HI),
    .HOLD_CYC(HOLD_CYC), .HOLD_LO(HOLD_LO), .HOLD_HI(HOLD_HI),
    .RDY_TIMEOUT(TMO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .busy_o(busy_o), .done_o(done_o), .resp_o(resp_o), .rdy_err_o(rdy_err_o),
    .sclk_o(sclk_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .rdy_i(rdy_i)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Slave model and timing monitor, sampled at falling system clock edges.
  logic [7:0] exp_cmd = 8'h00, exp_rsp = 8'h00, rx_mosi;
  logic prev_ss = 1'b1, prev_sclk = 1'b1, prev_mosi = 1'b0, prev_done = 1'b0;
  int t_ssf = 0, t_fall = 0, t_rise = 0, t_err = 0;
  int nfall = 0, nrise = 0, dones = 0, errs = 0, ss_falls = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      miso_i = 1'b0;
    end else begin
      if (ss_n_o && !sclk_o) chk(0, "R6 clock low while deselected", 0, 1);
      if (mosi_o !== prev_mosi && !(prev_sclk && !sclk_o))
        chk(0, "R7 mosi moved away from a falling edge", int'(mosi_o), int'(prev_mosi));
      if (prev_ss && !ss_n_o) begin
        t_ssf = cyc; ss_falls++; nfall = 0; nrise = 0; rx_mosi = 8'h00;
      end
      if (prev_sclk && !sclk_o) begin
        if (nfall == 0) chk(cyc - t_ssf == SET_E, "R5 R10 setup gap", cyc - t_ssf, SET_E);
        else            chk(cyc - t_rise == HALF_E, "R6 R10 high phase", cyc - t_rise, HALF_E);
        if (nfall < 8) miso_i = exp_rsp[7 - nfall];
        t_fall = cyc;
        nfall++;
      end
      if (!prev_sclk && sclk_o) begin
        chk(cyc - t_fall == HALF_E, "R6 R10 low phase", cyc - t_fall, HALF_E);
        rx_mosi = {rx_mosi[6:0], mosi_o};
        t_rise = cyc;
        nrise++;
      end
      if (!prev_ss && ss_n_o) begin
        chk(cyc - t_rise == HOLD_E, "R9 R10 hold gap", cyc - t_rise, HOLD_E);
        chk(nfall == 8, "R6 falling edge count", nfall, 8);
        chk(nrise == 8, "R6 rising edge count", nrise, 8);
        chk(done_o == 1'b1, "R9 done with select release", int'(done_o), 1);
        chk(resp_o == exp_rsp, "R8 response byte", int'(resp_o), int'(exp_rsp));
        chk(rx_mosi == exp_cmd, "R7 mosi byte", int'(rx_mosi), int'(exp_cmd));
      end
      if (done_o) begin
        dones++;
        if (prev_done) chk(0, "R9 done longer than one cycle", 2, 1);
      end
      if (rdy_err_o) begin
        errs++;
        t_err = cyc;
      end
      prev_ss = ss_n_o; prev_sclk = sclk_o; prev_mosi = mosi_o; prev_done = done_o;
    end
  end

  task automatic xfer(input logic [7:0] c, input logic [7:0] r,
                      input bit poke, input int wait_n);
    int tr, sf0;
    exp_cmd = c; exp_rsp = r; tr = 0;
    if (wait_n > 0) begin
      rdy_i = 1'b0;
      repeat (3) @(negedge clk);
    end
    sf0 = ss_falls;
    start_i = 1'b1; cmd_i = c;
    @(negedge clk);
    start_i = 1'b0; cmd_i = ~c;
    chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    if (wait_n > 0) begin
      repeat (wait_n) @(negedge clk);
      chk(ss_n_o == 1'b1, "R3 select held while not ready", int'(ss_n_o), 1);
      rdy_i = 1'b1;
      tr = cyc;
    end
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int k = 0; k < 400 && !done_o; k++) @(negedge clk);
    chk(done_o == 1'b1, "R9 done reached", int'(done_o), 1);
    chk(resp_o == r, "R8 response at done", int'(resp_o), int'(r));
    if (wait_n > 0) chk(t_ssf - tr == 3, "R3 select after ready", t_ssf - tr, 3);
    @(negedge clk);
    chk(busy_o == 1'b0, "R2 idle after done", int'(busy_o), 0);
    repeat (4) @(negedge clk);
    chk(resp_o == r, "R9 response held", int'(resp_o), int'(r));
    if (poke) begin
      repeat (30) @(negedge clk);
      chk(!busy_o && ss_n_o, "R2 start while busy ignored", int'(busy_o), 0);
      chk(ss_falls == sf0 + 1, "R2 single select per request", ss_falls - sf0, 1);
    end
  endtask

  task automatic timeout_run(input logic [7:0] c);
    int c0, e0, d0, sf0;
    rdy_i = 1'b0;
    repeat (3) @(negedge clk);
    e0 = errs; d0 = dones; sf0 = ss_falls; c0 = cyc;
    start_i = 1'b1; cmd_i = c;
    @(negedge clk);
    start_i = 1'b0;
    repeat (TMO + 5) @(negedge clk);
    chk(errs == e0 + 1, "R4 one error pulse", errs - e0, 1);
    chk(t_err == c0 + 1 + TMO, "R4 error timing", t_err - c0, 1 + TMO);
    chk(busy_o == 1'b0, "R4 back to idle", int'(busy_o), 0);
    chk(ss_falls == sf0, "R4 no select on timeout", ss_falls - sf0, 0);
    chk(dones == d0, "R4 no done on timeout", dones - d0, 0);
    rdy_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ss_n_o && sclk_o, "R1 lines idle in reset", int'({ss_n_o, sclk_o}), 3);
    chk(!busy_o && !done_o && !rdy_err_o, "R1 flags low in reset",
        int'({busy_o, done_o, rdy_err_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ss_n_o && sclk_o && !busy_o, "R1 idle after reset",
        int'({ss_n_o, sclk_o, busy_o}), 6);
    timeout_run(8'h3C);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] c;
      c = 8'(i);
      xfer(c, {c[3:0], c[7:4]} ^ 8'h5A, (i % 64) == 7, ((i % 50) == 3) ? (i % 5) + 2 : 0);
      if (i == 128) timeout_run(8'hC3);
    end
    repeat (10) @(negedge clk);
    chk(dones == 256, "R9 total done pulses", dones, 256);
    chk(errs == 2, "R4 total error pulses", errs, 2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule